// File: doc/BRIEF.md
# Serial Controller Interrupt and Output-Port Block

This block is the part of a two-channel serial controller that the channels share. It collects each channel's transmit-ready and receive-ready levels into one interrupt status byte. A write-only mask selects which status bits may interrupt, and an active-low request line is pulled low while any selected bit is set. The block sits on the same byte-wide register bus as the channel registers, and one access is decoded per clock.

The block also owns a general-purpose output port. Software never writes that port directly. One address sets the port bits that are marked with 1 in the written byte, and a second address clears the marked bits. Through an output-configuration register, each pin can be handed instead to an alternate source that another block drives. The pins carry the inverse of the selected bits. An input port samples external pins through a synchronizer. An auxiliary control register is also held here, and its top bit selects which baud-rate set the channels use.

Top module: `iop_top`

## Requirements
- R1: After reset, `irq_n` is 1, every `out_pins_n` bit is 1 (port register all 0), `aux_ctrl` is 0x00, `baud_set_sel` is 0 and the interrupt mask is 0.
- R2: A read of offset 0x5 returns the status byte. For channel n, the transmit-ready level registered on the previous clock appears at bit 4n and the receive-ready level at bit 4n+1. All other bits read 0.
- R3: A write to offset 0x5 loads the interrupt mask from the data byte. A read of offset 0x5 never returns the mask.
- R4: `irq_n` is 0 exactly while the bitwise AND of the status byte and the mask is non-zero, and it is 1 otherwise.
- R5: A write to offset 0xE sets every port bit whose data bit is 1. Port bits written as 0 keep their value.
- R6: A write to offset 0xF clears every port bit whose data bit is 1. Port bits written as 0 keep their value.
- R7: A write to offset 0xD loads the output configuration. Where a configuration bit is 0, pin i equals the inverse of port bit i. Where it is 1, pin i equals the inverse of `alt_src[i]`.
- R8: A read of offset 0xD returns the input pins after two register stages: a pin change is not visible after one clock and is visible after two. Bits 7:6 read as 1.
- R9: A write to offset 0x4 loads `aux_ctrl` from the data byte, and `baud_set_sel` equals bit 7 of that byte.
- R10: The output port is unchanged by writes to any offset other than 0xE and 0xF, and by any cycle with `bus_sel` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational; 0 when not reading |
| ch_tx_rdy | input | 2 | Per-channel transmit-ready level |
| ch_rx_rdy | input | 2 | Per-channel receive-ready level |
| in_pins | input | 6 | Asynchronous input pins |
| alt_src | input | 8 | Alternate drive for each output pin |
| out_pins_n | output | 8 | Output pins, inverted |
| aux_ctrl | output | 8 | Auxiliary control register |
| baud_set_sel | output | 1 | Baud-rate set select (aux bit 7) |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with its defaults: two channels with a stride of four status bits, six input pins, eight output pins and two synchronizer stages. With these values, both channels' status bits (bits 0, 1, 4 and 5) can be reached and masked singly. The padding rule for the two unused input-port bits is exercised. The two-stage delay can be seen by reading the input port one clock and then two clocks after a pin change. With eight output bits, mixed set, clear and alternate-source patterns cover every pin.

// File: rtl/iop_pkg.sv
package iop_pkg;
    localparam int unsigned ADDR_W = 4;
    localparam logic [ADDR_W-1:0] OFS_AUX  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_IRQ  = 4'h5;
    localparam logic [ADDR_W-1:0] OFS_PCFG = 4'hD;
    localparam logic [ADDR_W-1:0] OFS_SET  = 4'hE;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 4'hF;

    typedef struct packed {
        logic wr_aux;
        logic wr_mask;
        logic wr_cfg;
        logic wr_set;
        logic wr_clr;
        logic rd_irq;
        logic rd_pin;
    } bus_dec_t;
endpackage

// File: rtl/iop_sync.sv
module iop_sync #(
    parameter int unsigned WIDTH  = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef logic [STAGES-1:0][WIDTH-1:0] chain_t;
    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/iop_irq_merge.sv
module iop_irq_merge #(
    parameter int unsigned NUM_CH    = 2,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CH_STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tx_rdy_i,
    input  logic [NUM_CH-1:0] rx_rdy_i,
    input  logic              mask_we_i,
    input  logic [DATA_W-1:0] mask_wdata_i,
    output logic [DATA_W-1:0] status_o,
    output logic              irq_n_o
);
    localparam int unsigned USED_BITS = NUM_CH * CH_STRIDE;

    typedef struct packed {
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] mask;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.status = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            st_d.status[n*CH_STRIDE]     = tx_rdy_i[n];
            st_d.status[n*CH_STRIDE + 1] = rx_rdy_i[n];
        end
        if (mask_we_i) st_d.mask = mask_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign irq_n_o  = ~|(st_q.status & st_q.mask);

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> st_q.mask == $past(mask_wdata_i)); // R3
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |-> irq_n_o); // R4
    AST_STATUS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> status_o[0] == $past(tx_rdy_i[0])); // R2
    AST_STATUS_FIT: assert property (@(posedge clk) disable iff (!rst_n)
        USED_BITS <= DATA_W); // R2
endmodule

// File: rtl/iop_out_port.sv
module iop_out_port #(
    parameter int unsigned OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we_i,
    input  logic             clr_we_i,
    input  logic [OUT_W-1:0] wdata_i,
    input  logic [OUT_W-1:0] cfg_i,
    input  logic [OUT_W-1:0] alt_src_i,
    output logic [OUT_W-1:0] pins_n_o
);
    typedef struct packed {
        logic [OUT_W-1:0] port;
    } op_state_t;

    op_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_we_i) st_d.port = st_q.port | wdata_i;
        if (clr_we_i) st_d.port = st_q.port & ~wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < OUT_W; i++) begin : g_pin
        assign pins_n_o[i] = ~(cfg_i[i] ? alt_src_i[i] : st_q.port[i]);
    end

    AST_SET_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        set_we_i |=> (st_q.port & $past(st_q.port)) == $past(st_q.port)); // R5
    AST_CLR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> (st_q.port & ~$past(st_q.port)) == '0); // R6
    AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we_i && !clr_we_i) |=> $stable(st_q.port)); // R10
    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({set_we_i, clr_we_i}) <= 1); // R10
endmodule

// File: rtl/iop_top.sv
module iop_top #(
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CH_STRIDE   = 4,
    parameter int unsigned IN_W        = 6,
    parameter int unsigned OUT_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [iop_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [NUM_CH-1:0]         ch_tx_rdy,
    input  logic [NUM_CH-1:0]         ch_rx_rdy,
    input  logic [IN_W-1:0]           in_pins,
    input  logic [OUT_W-1:0]          alt_src,
    output logic [OUT_W-1:0]          out_pins_n,
    output logic [DATA_W-1:0]         aux_ctrl,
    output logic                      baud_set_sel,
    output logic                      irq_n
);
    import iop_pkg::*;

    localparam int unsigned BAUD_BIT = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] aux;
        logic [OUT_W-1:0]  cfg;
    } ctl_state_t;

    bus_dec_t          dec;
    ctl_state_t        ctl_d, ctl_q;
    logic [DATA_W-1:0] status;
    logic [IN_W-1:0]   pins_sync;
    logic [DATA_W-1:0] pin_word;

    always_comb begin
        dec = '0;
        if (bus_sel && bus_wr) begin
            dec.wr_aux  = (bus_addr == OFS_AUX);
            dec.wr_mask = (bus_addr == OFS_IRQ);
            dec.wr_cfg  = (bus_addr == OFS_PCFG);
            dec.wr_set  = (bus_addr == OFS_SET);
            dec.wr_clr  = (bus_addr == OFS_CLR);
        end
        if (bus_sel && !bus_wr) begin
            dec.rd_irq = (bus_addr == OFS_IRQ);
            dec.rd_pin = (bus_addr == OFS_PCFG);
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        if (dec.wr_aux) ctl_d.aux = bus_wdata;
        if (dec.wr_cfg) ctl_d.cfg = bus_wdata[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    iop_irq_merge #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_STRIDE(CH_STRIDE)
    ) u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_rdy_i(ch_tx_rdy), .rx_rdy_i(ch_rx_rdy),
        .mask_we_i(dec.wr_mask), .mask_wdata_i(bus_wdata),
        .status_o(status), .irq_n_o(irq_n)
    );

    iop_out_port #(.OUT_W(OUT_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .set_we_i(dec.wr_set), .clr_we_i(dec.wr_clr),
        .wdata_i(bus_wdata[OUT_W-1:0]), .cfg_i(ctl_q.cfg),
        .alt_src_i(alt_src), .pins_n_o(out_pins_n)
    );

    iop_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(in_pins), .sync_o(pins_sync)
    );

    always_comb begin
        pin_word = '1;
        pin_word[IN_W-1:0] = pins_sync;
    end

    always_comb begin
        bus_rdata = '0;
        if (dec.rd_irq) bus_rdata = status;
        if (dec.rd_pin) bus_rdata = pin_word;
    end

    assign aux_ctrl     = ctl_q.aux;
    assign baud_set_sel = ctl_q.aux[BAUD_BIT];

    AST_BAUD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        dec.wr_aux |=> baud_set_sel == $past(bus_wdata[BAUD_BIT])); // R9
    AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec)); // R10
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.wr_cfg |=> $stable(ctl_q.cfg)); // R7
endmodule

// File: tb/tb_iop_top.sv
module tb_iop_top;
    import iop_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [1:0] ch_tx_rdy = '0, ch_rx_rdy = '0;
    logic [5:0] in_pins = '0;
    logic [7:0] alt_src = '0, out_pins_n, aux_ctrl;
    logic       baud_set_sel, irq_n;
    int         n_checks = 0, n_fails = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    iop_top dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_tx_rdy(ch_tx_rdy), .ch_rx_rdy(ch_rx_rdy), .in_pins(in_pins),
        .alt_src(alt_src), .out_pins_n(out_pins_n), .aux_ctrl(aux_ctrl),
        .baud_set_sel(baud_set_sel), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [7:0] exp_status(input logic [1:0] tx, input logic [1:0] rx);
        logic [7:0] s = '0;
        for (int n = 0; n < 2; n++) begin
            s[4*n] = tx[n];
            s[4*n+1] = rx[n];
        end
        return s;
    endfunction

    task automatic t_reset;
        logic [7:0] r;
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        check("R1 pins", out_pins_n, 8'hFF);
        check("R1 aux", aux_ctrl, 8'h00);
        check("R1 baud", {7'd0, baud_set_sel}, 8'h00);
        ch_tx_rdy = 2'b11; ch_rx_rdy = 2'b11;
        @(negedge clk);
        check("R1 mask zero irq", {7'd0, irq_n}, 8'h01);
        ch_tx_rdy = '0; ch_rx_rdy = '0;
        @(negedge clk);
        bus_read(OFS_IRQ, r);
        check("R1 status", r, 8'h00);
    endtask

    task automatic t_status_map;
        logic [7:0] r;
        logic [1:0] pats [4] = '{2'b01, 2'b10, 2'b11, 2'b00};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ch_tx_rdy = pats[i]; ch_rx_rdy = pats[(i+1)%4];
            @(negedge clk);
            bus_read(OFS_IRQ, r);
            check("R2 status map", r, exp_status(pats[i], pats[(i+1)%4]));
        end
    endtask

    task automatic t_mask_irq;
        logic [7:0] r;
        ch_tx_rdy = '0; ch_rx_rdy = '0;
        bus_write(OFS_IRQ, 8'hFF);
        bus_read(OFS_IRQ, r);
        check("R3 read is status not mask", r, 8'h00);
        check("R4 no status no irq", {7'd0, irq_n}, 8'h01);
        bus_write(OFS_IRQ, 8'h02);
        ch_tx_rdy = 2'b01;
        @(negedge clk);
        check("R4 unmasked bit no irq", {7'd0, irq_n}, 8'h01);
        bus_write(OFS_IRQ, 8'h01);
        check("R3 R4 mask tx0 irq", {7'd0, irq_n}, 8'h00);
        ch_tx_rdy = '0; bus_write(OFS_IRQ, 8'h20);
        ch_rx_rdy = 2'b10;
        @(negedge clk);
        check("R4 rx1 irq", {7'd0, irq_n}, 8'h00);
        ch_rx_rdy = 2'b00;
        @(negedge clk);
        check("R4 rx1 drop", {7'd0, irq_n}, 8'h01);
        bus_write(OFS_IRQ, 8'h00);
    endtask

    task automatic t_set_clear;
        logic [7:0] port = 8'h00;
        bus_write(OFS_SET, 8'h5A); port = port | 8'h5A;
        check("R5 set", out_pins_n, ~port);
        bus_write(OFS_SET, 8'h81); port = port | 8'h81;
        check("R5 set keeps", out_pins_n, ~port);
        bus_write(OFS_CLR, 8'h18); port = port & ~8'h18;
        check("R6 clear", out_pins_n, ~port);
        bus_write(OFS_CLR, 8'h00);
        check("R6 clear zero", out_pins_n, ~port);
        bus_write(OFS_SET, 8'h00);
        check("R5 set zero", out_pins_n, ~port);
    endtask

    task automatic t_cfg_alt;
        logic [7:0] port = 8'hC3;
        bus_write(OFS_CLR, 8'hFF);
        bus_write(OFS_SET, port);
        alt_src = 8'hA5;
        bus_write(OFS_PCFG, 8'hF0);
        check("R7 alt mix", out_pins_n, ~((port & 8'h0F) | (alt_src & 8'hF0)));
        alt_src = 8'h5A;
        #1 check("R7 alt follow", out_pins_n, ~((port & 8'h0F) | (alt_src & 8'hF0)));
        bus_write(OFS_PCFG, 8'h00);
        check("R7 cfg zero", out_pins_n, ~port);
    endtask

    task automatic t_input_sync;
        logic [7:0] r;
        @(negedge clk);
        bus_read(OFS_PCFG, r);
        check("R8 idle pins", r, 8'hC0);
        in_pins = 6'h2A;
        @(negedge clk);
        bus_read(OFS_PCFG, r);
        check("R8 one stage", r, 8'hC0);
        @(negedge clk);
        bus_read(OFS_PCFG, r);
        check("R8 two stages", r, {2'b11, 6'h2A});
        in_pins = 6'h3F;
        @(negedge clk); @(negedge clk);
        bus_read(OFS_PCFG, r);
        check("R8 all high", r, 8'hFF);
    endtask

    task automatic t_aux;
        bus_write(OFS_AUX, 8'h8C);
        check("R9 aux", aux_ctrl, 8'h8C);
        check("R9 baud set", {7'd0, baud_set_sel}, 8'h01);
        bus_write(OFS_AUX, 8'h71);
        check("R9 baud clear", {7'd0, baud_set_sel}, 8'h00);
    endtask

    task automatic t_ignore;
        logic [7:0] port = 8'h3C;
        bus_write(OFS_CLR, 8'hFF);
        bus_write(OFS_SET, port);
        bus_write(OFS_IRQ, 8'hFF);
        bus_write(OFS_AUX, 8'hFF);
        bus_write(4'h3, 8'hFF);
        check("R10 other offsets", out_pins_n, ~port);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = OFS_SET; bus_wdata = 8'hFF;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10 no select", out_pins_n, ~port);
        bus_write(OFS_IRQ, 8'h00);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status_map();
        t_mask_irq();
        t_set_clear();
        t_cfg_alt();
        t_input_sync();
        t_aux();
        t_ignore();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule